// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block is a 16-bit up-counting timer with two compare registers and one compare output pin. A two-bit clock-select field sets the rate at which the counter advances. It can divide the system clock by 4, 8 or 16, or it can stop the counter. When the counter matches compare 1, the pin takes a programmed level. In pulse-width mode, a match on compare 2 drives the pin to a second programmed level. The same match reloads the counter with FFFCh, so compare 2 sets the period and compare 1 sets the duty edge.

Software loads the compare registers one byte at a time through a simple write strobe. Writing the upper byte of a compare register disables that comparison. It stays disabled until the lower byte is written, so a half-updated value can never cause a match. Outside pulse-width mode, each match sets a sticky flag. Writing that register's lower byte clears the flag. In pulse-width mode the flags stay low.

Top module: `pwm_cmp_timer`

## Requirements
- R1: After a synchronous reset the count is 0000h, the pin and both flags are low, the clock select is "stopped", both compare registers hold FFFFh and both comparisons are enabled.
- R2: Control bits [6:5] select the counter rate. 00 gives one tick every 4 clocks, 01 every 8 and 10 every 16. With 11 the count is frozen. Each tick adds one to the count, and FFFFh rolls over to 0000h.
- R3: On a tick where the count equals enabled compare 1, the pin takes control bit 0, provided the output-enable bit (control bit 2) is set.
- R4: Pulse-width mode needs both control bit 3 and the output-enable bit. In this mode, a tick where the count equals enabled compare 2 loads FFFCh into the counter and drives control bit 1 onto the pin. Outside this mode the counter simply increments.
- R5: In pulse-width mode, if both compare registers hold the same value, the compare-2 action wins: the pin takes control bit 1 and the counter reloads.
- R6: Write addresses are 0 control, 1 and 2 compare-1 upper and lower byte, and 3 and 4 compare-2 upper and lower byte. An upper-byte write disables that comparison. It stays disabled until the lower byte is written.
- R7: When control bit 3 is clear, a tick that matches an enabled compare register sets that register's flag. The flag stays set until that register's lower byte is written. When control bit 3 is set, no flag is ever set.
- R8: Control bit 4 (single-pulse request) has no effect when bit 3 is set; reload and pulse width behave exactly as in plain pulse-width mode.
- R9: While the output-enable bit is clear, the pin output is low and matches do not change the held level.
- R10: In pulse-width mode the period is compare2+5 ticks. With bit 0 = 0 and bit 1 = 1 the high time is compare1+5 ticks. With bit 0 = 1 and bit 1 = 0 it is compare2-compare1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 8 | Write byte |
| cnt_val | output | 16 | Current counter value |
| cmp_out | output | 1 | Compare output pin |
| flag_cmp1 | output | 1 | Compare-1 match flag |
| flag_cmp2 | output | 1 | Compare-2 match flag |

## Verification
Two functions can land on the same tick: the duty-edge match on compare 1 and the period match on compare 2. Programming both registers to the same value makes them coincide on every period. The pin must then settle on the compare-2 level and hold it, and the counter must reload to FFFCh each time. A cycle-accurate scoreboard checks every clock. Separately, a flag being set and its lower-byte clear are kept apart in time, and this shows the flags stay silent once pulse-width mode is on.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int ADDR_W = 3;
    localparam int N_CMP  = 2;

    typedef enum logic [1:0] {
        CLK_DIV4  = 2'b00,
        CLK_DIV8  = 2'b01,
        CLK_DIV16 = 2'b10,
        CLK_HOLD  = 2'b11
    } clk_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_C1_HI = 3'd1,
        A_C1_LO = 3'd2,
        A_C2_HI = 3'd3,
        A_C2_LO = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        MODE_FREE,
        MODE_ONE_PULSE,
        MODE_PWM
    } tmr_mode_e;

    // bit 0 lvl1, bit 1 lvl2, bit 2 out_en, bit 3 pwm_en, bit 4 one_pulse, bits 6:5 clk_sel
    typedef struct packed {
        clk_sel_e clk_sel;
        logic     one_pulse;
        logic     pwm_en;
        logic     out_en;
        logic     lvl2;
        logic     lvl1;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RESET = '{clk_sel: CLK_HOLD, default: 1'b0};

    function automatic logic [3:0] div_mask(input clk_sel_e sel);
        case (sel)
            CLK_DIV4:  return 4'd3;
            CLK_DIV8:  return 4'd7;
            CLK_DIV16: return 4'd15;
            default:   return 4'd0;
        endcase
    endfunction

    // the pulse-width mode wins over the single-pulse request
    function automatic tmr_mode_e pick_mode(input ctrl_t c);
        if (c.pwm_en && c.out_en) return MODE_PWM;
        if (c.one_pulse)          return MODE_ONE_PULSE;
        return MODE_FREE;
    endfunction

endpackage

// File: rtl/pwm_tmr_prescaler.sv
module pwm_tmr_prescaler
    import pwm_tmr_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    output logic     tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = PRE_W'(div_mask(sel));
        tick = (sel != CLK_HOLD) && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (sel != CLK_HOLD) begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_tmr_cmp_reg.sv
module pwm_tmr_cmp_reg #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_hi,
    input  logic               wr_lo,
    input  logic [CNT_W/2-1:0] wr_byte,
    output logic [CNT_W-1:0]   val,
    output logic               armed
);

    localparam int HALF_W = CNT_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            val   <= '1;
            armed <= 1'b1;
        end else if (wr_hi) begin
            val[CNT_W-1:HALF_W] <= wr_byte;
            armed               <= 1'b0;
        end else if (wr_lo) begin
            val[HALF_W-1:0] <= wr_byte;
            armed           <= 1'b1;
        end
    end

endmodule

// File: rtl/pwm_tmr_core.sv
module pwm_tmr_core
    import pwm_tmr_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] RELOAD_VAL = 16'hFFFC
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick,
    input  ctrl_t                       ctrl,
    input  logic [N_CMP-1:0][CNT_W-1:0] cmp_val,
    input  logic [N_CMP-1:0]            armed,
    input  logic [N_CMP-1:0]            flag_clr,
    output logic [CNT_W-1:0]            cnt,
    output logic                        pin,
    output logic [N_CMP-1:0]            flags
);

    tmr_mode_e        mode;
    logic [N_CMP-1:0] hit;
    logic             period_end;

    always_comb begin
        mode = pick_mode(ctrl);
        for (int i = 0; i < N_CMP; i++) begin
            hit[i] = armed[i] && (cnt == cmp_val[i]);
        end
        period_end = (mode == MODE_PWM) && hit[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= period_end ? RELOAD_VAL : cnt + 1'b1;
        end
    end

    // compare-2 action has priority over compare-1 on the same tick
    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b0;
        end else if (tick && ctrl.out_en) begin
            if (period_end) begin
                pin <= ctrl.lvl2;
            end else if (hit[0]) begin
                pin <= ctrl.lvl1;
            end
        end
    end

    for (genvar i = 0; i < N_CMP; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else if (tick && !ctrl.pwm_en && hit[i]) begin
                flags[i] <= 1'b1;
            end else if (flag_clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 4,
    parameter int RELOAD_BACK = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W/2-1:0] wr_data,
    output logic [CNT_W-1:0]   cnt_val,
    output logic               cmp_out,
    output logic               flag_cmp1,
    output logic               flag_cmp2
);

    localparam logic [CNT_W-1:0] RELOAD_VAL = {CNT_W{1'b1}} - CNT_W'(RELOAD_BACK - 1);

    ctrl_t                       ctrl_q;
    logic                        tick_w;
    logic [N_CMP-1:0][CNT_W-1:0] cmp_val;
    logic [N_CMP-1:0]            armed;
    logic [N_CMP-1:0]            wr_hi;
    logic [N_CMP-1:0]            wr_lo;
    logic                        pin_q;
    logic [N_CMP-1:0]            flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_en && wr_addr == A_CTRL) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    pwm_tmr_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (ctrl_q.clk_sel),
        .tick (tick_w)
    );

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(1 + 2 * i);
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(2 + 2 * i);

        assign wr_hi[i] = wr_en && (wr_addr == HI_A);
        assign wr_lo[i] = wr_en && (wr_addr == LO_A);

        pwm_tmr_cmp_reg #(.CNT_W(CNT_W)) i_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_hi   (wr_hi[i]),
            .wr_lo   (wr_lo[i]),
            .wr_byte (wr_data),
            .val     (cmp_val[i]),
            .armed   (armed[i])
        );
    end

    pwm_tmr_core #(.CNT_W(CNT_W), .RELOAD_VAL(RELOAD_VAL)) i_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_w),
        .ctrl     (ctrl_q),
        .cmp_val  (cmp_val),
        .armed    (armed),
        .flag_clr (wr_lo),
        .cnt      (cnt_val),
        .pin      (pin_q),
        .flags    (flags_q)
    );

    assign cmp_out   = ctrl_q.out_en & pin_q;
    assign flag_cmp1 = flags_q[0];
    assign flag_cmp2 = flags_q[1];

endmodule

// File: rtl/pwm_cmp_timer_chk.sv
module pwm_cmp_timer_chk
    import pwm_tmr_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] RELOAD_VAL = 16'hFFFC
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [CNT_W-1:0]            cnt_val,
    input logic                        cmp_out,
    input logic                        flag_cmp1,
    input logic                        flag_cmp2,
    input logic                        tick,
    input ctrl_t                       ctrl_q,
    input logic [N_CMP-1:0][CNT_W-1:0] cmp_val,
    input logic [N_CMP-1:0]            armed
);

    logic pwm_on;
    logic m1;
    logic m2;
    assign pwm_on = ctrl_q.pwm_en && ctrl_q.out_en;
    assign m1     = armed[0] && (cnt_val == cmp_val[0]);
    assign m2     = armed[1] && (cnt_val == cmp_val[1]);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.clk_sel == CLK_HOLD |=> $stable(cnt_val));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        tick && !(pwm_on && m2) |=> cnt_val == CNT_W'($past(cnt_val) + 1'b1));

    p_duty_level_r3: assert property (@(posedge clk) disable iff (rst)
        tick && ctrl_q.out_en && m1 && !(pwm_on && m2)
        |=> !ctrl_q.out_en || cmp_out == $past(ctrl_q.lvl1));

    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        tick && pwm_on && m2 |=> cnt_val == RELOAD_VAL && (!ctrl_q.out_en || cmp_out == $past(ctrl_q.lvl2)));

    p_tie_r5: assert property (@(posedge clk) disable iff (rst)
        tick && pwm_on && m1 && m2 |=> !ctrl_q.out_en || cmp_out == $past(ctrl_q.lvl2));

    p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_addr == A_C1_HI || wr_addr == A_C2_HI)
        |=> !(armed[0] && armed[1]));

    p_rearm_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == A_C2_LO |=> armed[1]);

    p_flag1_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.pwm_en && !flag_cmp1 |=> !flag_cmp1);

    p_flag2_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.pwm_en && !flag_cmp2 |=> !flag_cmp2);

    p_single_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.one_pulse && pwm_on && tick && m2 |=> cnt_val == RELOAD_VAL);

endmodule

bind pwm_cmp_timer pwm_cmp_timer_chk #(.CNT_W(CNT_W), .RELOAD_VAL(RELOAD_VAL)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .cnt_val   (cnt_val),
    .cmp_out   (cmp_out),
    .flag_cmp1 (flag_cmp1),
    .flag_cmp2 (flag_cmp2),
    .tick      (tick_w),
    .ctrl_q    (ctrl_q),
    .cmp_val   (cmp_val),
    .armed     (armed)
);

// File: tb/test_pwm_cmp_timer.sv
module test_pwm_cmp_timer;
    import pwm_tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] cnt_val;
    logic        cmp_out;
    logic        flag_cmp1;
    logic        flag_cmp2;

    pwm_cmp_timer i_pwm_cmp_timer (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt_val   (cnt_val),
        .cmp_out   (cmp_out),
        .flag_cmp1 (flag_cmp1),
        .flag_cmp2 (flag_cmp2)
    );

    always #10 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    // ---------------- reference model and scoreboard ----------------
    typedef struct {
        logic [15:0] cnt;
        logic        pin;
        logic        f1;
        logic        f2;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] m_cnt, m_c1, m_c2;
    logic [3:0]  m_pre;
    logic        m_pin, m_f1, m_f2, m_a1, m_a2;
    logic        m_l1, m_l2, m_oe, m_pwm, m_opm;
    logic [1:0]  m_sel;

    always @(posedge clk) begin : model
        logic [3:0] mask;
        bit         tk, h1, h2, on, s1, s2;
        exp_t       e;
        if (rst) begin
            m_cnt = 16'h0000; m_c1 = 16'hFFFF; m_c2 = 16'hFFFF;
            m_pre = 4'd0; m_pin = 1'b0; m_f1 = 1'b0; m_f2 = 1'b0;
            m_a1 = 1'b1; m_a2 = 1'b1;
            m_l1 = 1'b0; m_l2 = 1'b0; m_oe = 1'b0; m_pwm = 1'b0; m_opm = 1'b0;
            m_sel = 2'b11;
        end else begin
            mask = (m_sel == 2'b00) ? 4'd3 : (m_sel == 2'b01) ? 4'd7 : 4'd15;
            tk   = (m_sel != 2'b11) && ((m_pre & mask) == mask);
            if (m_sel != 2'b11) m_pre = m_pre + 4'd1;
            h1 = m_a1 && (m_cnt == m_c1);
            h2 = m_a2 && (m_cnt == m_c2);
            on = m_pwm && m_oe;
            s1 = tk && !m_pwm && h1;
            s2 = tk && !m_pwm && h2;
            if (tk) begin
                if (on && h2) begin
                    m_cnt = 16'hFFFC;
                    if (m_oe) m_pin = m_l2;
                end else begin
                    m_cnt = m_cnt + 16'd1;
                    if (m_oe && h1) m_pin = m_l1;
                end
            end
            if (wr_en && wr_addr == 3'd2) m_f1 = 1'b0;
            if (wr_en && wr_addr == 3'd4) m_f2 = 1'b0;
            if (s1) m_f1 = 1'b1;
            if (s2) m_f2 = 1'b1;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        m_l1 = wr_data[0]; m_l2 = wr_data[1]; m_oe = wr_data[2];
                        m_pwm = wr_data[3]; m_opm = wr_data[4]; m_sel = wr_data[6:5];
                    end
                    3'd1: begin m_c1[15:8] = wr_data; m_a1 = 1'b0; end
                    3'd2: begin m_c1[7:0]  = wr_data; m_a1 = 1'b1; end
                    3'd3: begin m_c2[15:8] = wr_data; m_a2 = 1'b0; end
                    3'd4: begin m_c2[7:0]  = wr_data; m_a2 = 1'b1; end
                    default: ;
                endcase
            end
        end
        e.cnt = m_cnt;
        e.pin = m_oe & m_pin;
        e.f1  = m_f1;
        e.f2  = m_f2;
        sb_q.push_back(e);
    end

    always @(negedge clk) begin : monitor
        exp_t e;
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check(cnt_val === e.cnt, cur_req, "scoreboard count", cnt_val, e.cnt);
            check(cmp_out === e.pin, cur_req, "scoreboard pin", cmp_out, e.pin);
            check({flag_cmp2, flag_cmp1} === {e.f2, e.f1}, cur_req, "scoreboard flags",
                  {flag_cmp2, flag_cmp1}, {e.f2, e.f1});
        end
    end

    // ---------------- driver tasks ----------------
    function automatic logic [7:0] mk_ctl(logic [1:0] sel, bit opm, bit pwm, bit oe, bit l2, bit l1);
        return {1'b0, sel, opm, pwm, oe, l2, l1};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_cmp(input logic [15:0] c1, input logic [15:0] c2);
        wr(A_C1_HI, c1[15:8]); wr(A_C1_LO, c1[7:0]);
        wr(A_C2_HI, c2[15:8]); wr(A_C2_LO, c2[7:0]);
    endtask

    task automatic wait_out(input logic v, input int lim, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (cmp_out === v) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_cnt(input logic [15:0] v, input int lim, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (cnt_val === v) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_cnt_moves(input int lim);
        logic [15:0] prev;
        prev = cnt_val;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (cnt_val !== prev) break;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        check(1'b0, cur_req, "watchdog expired", cyc, 0);
        finish_run();
    end

    // ---------------- test sequence ----------------
    initial begin : driver
        bit ok;
        int t_rise, t_fall, t_rise2;

        // R1: reset state
        cur_req = "R1";
        do_reset();
        check(cnt_val === 16'h0000, "R1", "count after reset", cnt_val, 0);
        check(cmp_out === 1'b0, "R1", "pin after reset", cmp_out, 0);
        check({flag_cmp2, flag_cmp1} === 2'b00, "R1", "flags after reset", {flag_cmp2, flag_cmp1}, 0);

        // R2: stopped clock, then each divider from a fresh reset
        cur_req = "R2";
        repeat (20) @(negedge clk);
        check(cnt_val === 16'h0000, "R2", "count frozen in hold", cnt_val, 0);
        wr(A_CTRL, mk_ctl(2'b10, 0, 0, 0, 0, 0));
        repeat (80) @(negedge clk);
        check(cnt_val === 16'd5, "R2", "divide-by-16 count", cnt_val, 5);
        do_reset();
        wr(A_CTRL, mk_ctl(2'b01, 0, 0, 0, 0, 0));
        repeat (80) @(negedge clk);
        check(cnt_val === 16'd10, "R2", "divide-by-8 count", cnt_val, 10);
        do_reset();
        wr(A_CTRL, mk_ctl(2'b00, 0, 0, 0, 0, 0));
        repeat (80) @(negedge clk);
        check(cnt_val === 16'd20, "R2", "divide-by-4 count", cnt_val, 20);

        // R3 / R10: inverted levels, high time = c2 - c1 ticks
        cur_req = "R3";
        do_reset();
        load_cmp(16'h0010, 16'h0030);
        wr(A_CTRL, mk_ctl(2'b00, 0, 1, 1, 0, 1));
        wait_out(1'b1, 200, ok);
        check(ok, "R3", "pin rises on compare-1 match", cmp_out, 1);
        check(cnt_val === 16'h0011, "R3", "count at duty edge", cnt_val, 16'h0011);
        t_rise = cyc;
        wait_out(1'b0, 400, ok);
        t_fall = cyc;
        check(ok && (t_fall - t_rise) == 128, "R10", "inverted high time", t_fall - t_rise, 128);

        // R4 / R10 / R2: main pulse-width run with the long values
        cur_req = "R4";
        do_reset();
        load_cmp(16'h2ED0, 16'h34E2);
        wr(A_CTRL, mk_ctl(2'b00, 0, 1, 1, 1, 0));
        wait_out(1'b1, 60000, ok);
        check(ok, "R4", "pin rises on period match", cmp_out, 1);
        check(cnt_val === 16'hFFFC, "R4", "reload value", cnt_val, 16'hFFFC);
        t_rise = cyc;
        wait_cnt_moves(8);
        check(cnt_val === 16'hFFFD, "R4", "step after reload", cnt_val, 16'hFFFD);
        wait_cnt(16'hFFFF, 16, ok);
        wait_cnt_moves(8);
        check(cnt_val === 16'h0000, "R2", "rollover to zero", cnt_val, 0);
        wait_out(1'b0, 60000, ok);
        t_fall = cyc;
        check(ok && (t_fall - t_rise) == 47956, "R10", "high time c1+5 ticks", t_fall - t_rise, 47956);
        wait_out(1'b1, 60000, ok);
        t_rise2 = cyc;
        check(ok && (t_rise2 - t_rise) == 54172, "R10", "period c2+5 ticks", t_rise2 - t_rise, 54172);

        // R5: equal registers, compare-2 wins
        cur_req = "R5";
        do_reset();
        load_cmp(16'h0020, 16'h0020);
        wr(A_CTRL, mk_ctl(2'b00, 0, 1, 1, 1, 0));
        wait_cnt(16'hFFFC, 300, ok);
        check(ok, "R5", "reload on tied match", cnt_val, 16'hFFFC);
        repeat (444) @(negedge clk);
        check(cmp_out === 1'b1, "R5", "pin holds compare-2 level", cmp_out, 1);

        // R6: upper-byte write disarms until the lower byte arrives
        cur_req = "R6";
        do_reset();
        load_cmp(16'h0010, 16'h0030);
        wr(A_C2_HI, 8'h00);
        wr(A_CTRL, mk_ctl(2'b00, 0, 1, 1, 1, 0));
        wait_cnt(16'h0031, 240, ok);
        check(ok, "R6", "count passes disarmed compare-2", cnt_val, 16'h0031);
        wr(A_C2_LO, 8'h40);
        wait_cnt(16'hFFFC, 200, ok);
        check(ok, "R6", "reload after rearm", cnt_val, 16'hFFFC);

        // R7: flags outside pulse-width mode, cleared by lower-byte write, silent inside it
        cur_req = "R7";
        do_reset();
        load_cmp(16'h0008, 16'h000C);
        wr(A_CTRL, mk_ctl(2'b00, 0, 0, 1, 0, 1));
        repeat (64) @(negedge clk);
        check({flag_cmp2, flag_cmp1} === 2'b11, "R7", "both flags set", {flag_cmp2, flag_cmp1}, 3);
        check(cmp_out === 1'b1, "R3", "free-run duty level", cmp_out, 1);
        check(cnt_val > 16'h000C && cnt_val < 16'h0020, "R4", "no reload outside mode", cnt_val, 16'h000F);
        wr(A_C1_LO, 8'h08);
        check({flag_cmp2, flag_cmp1} === 2'b10, "R7", "flag1 cleared only", {flag_cmp2, flag_cmp1}, 2);
        wr(A_CTRL, mk_ctl(2'b00, 0, 1, 1, 0, 1));
        wr(A_C2_HI, 8'h00);
        wr(A_C2_LO, 8'h30);
        wr(A_C1_LO, 8'h28);
        wait_cnt(16'hFFFC, 400, ok);
        check(ok, "R7", "reload in pulse-width mode", cnt_val, 16'hFFFC);
        repeat (200) @(negedge clk);
        check({flag_cmp2, flag_cmp1} === 2'b00, "R7", "flags silent in pulse-width mode",
              {flag_cmp2, flag_cmp1}, 0);

        // R8: single-pulse bit with pulse-width bit set changes nothing
        cur_req = "R8";
        do_reset();
        load_cmp(16'h0010, 16'h0030);
        wr(A_CTRL, mk_ctl(2'b00, 1, 1, 1, 1, 0));
        wait_out(1'b1, 300, ok);
        check(ok && cnt_val === 16'hFFFC, "R8", "reload with single-pulse bit", cnt_val, 16'hFFFC);
        t_rise = cyc;
        wait_out(1'b0, 300, ok);
        t_fall = cyc;
        check(ok && (t_fall - t_rise) == 84, "R8", "high time unchanged", t_fall - t_rise, 84);

        // R9: output disabled, pulse-width bit alone does not reload
        cur_req = "R9";
        do_reset();
        load_cmp(16'h0010, 16'h0020);
        wr(A_CTRL, mk_ctl(2'b00, 0, 1, 0, 1, 0));
        wait_cnt(16'h0024, 200, ok);
        check(ok, "R9", "no reload without output enable", cnt_val, 16'h0024);
        check(cmp_out === 1'b0, "R9", "pin low while disabled", cmp_out, 0);
        wr(A_CTRL, mk_ctl(2'b00, 0, 1, 1, 1, 0));
        repeat (8) @(negedge clk);
        check(cmp_out === 1'b0, "R9", "held level unchanged by disabled matches", cmp_out, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule